// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a free-running timer. It watches an externally supplied counter value. Depending on a 4-bit configuration field, it does one of four things:

- It timestamps edges on an input pin (input capture).
- It changes an output level when the counter reaches a programmed value (output compare or PWM), with the new compare value taking effect at once.
- It does the same compare work, but with a double-buffered compare value that only takes effect at counter overflow, so a PWM period is never cut short.
- It stays off the pin entirely, leaving the pin to general-purpose port logic.

While the channel is off the pin, the configuration field still selects the level that the channel will present once an output mode is enabled. Software is expected to stop and reset the counter before changing the configuration. Every capture or compare match produces a one-cycle event pulse, which the surrounding timer can route to an interrupt or a status flag.

The configuration field is `cfg_data[3:0]`:

| Bit | Name | Meaning |
|-----|------|---------|
| 3 | B | Mode bit B |
| 2 | A | Mode bit A |
| 1:0 | E | Edge/level code |

Top module: `capcmp_channel`

## Requirements
- R1: With edge/level code E = 00, `pin_oe` is 0 and no capture or event occurs.
- R2: With E = 00, the held output level becomes high when A = 0 and low when A = 1, one clock after the configuration is written. When a compare mode is then enabled, `pin_out` starts at that held level.
- R3: Reset clears the configuration to 0000, `cap_val` to 0 and `chan_evt` to 0. `pin_out` reads high after reset.
- R4: With B:A = 00 and E ≠ 00, a qualified pin edge copies `cnt_val` into `cap_val` and pulses `chan_evt` for one cycle. E = 01 qualifies rising edges only, E = 10 falling edges only, and E = 11 both. The result appears on the third rising clock edge after the pin change.
- R5: With B:A = 01, a cycle in which `cnt_val` equals the active compare value changes `pin_out` on the next clock edge and pulses `chan_evt` at the same edge. E = 01 toggles the level, E = 10 drives it to 0, and E = 11 drives it to 1.
- R6: With B = 1, a written compare value is held pending. It becomes the active compare value only at a clock edge where `cnt_ovf` is 1. The old value keeps matching until then. The toggle, clear and set actions are the same as in R5.
- R7: With B = 0, a compare value written by `cmp_we` is active from the next cycle.
- R8: `pin_oe` is 1 in both compare modes when E ≠ 00, and 0 in input capture mode.
- R9: Enabling capture while the pin has been stable for several cycles produces no capture and no event.
- R10: In compare modes, pin edges cause no capture. In capture mode, a counter value equal to the compare register causes no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current timer counter value |
| cnt_ovf | input | 1 | Counter overflow strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 4 | Configuration {B, A, E[1:0]} |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_data | input | CNT_W | Compare value to write |
| pin_in | input | 1 | Raw pin sample |
| pin_oe | output | 1 | Channel drives the pin |
| pin_out | output | 1 | Channel output level |
| cap_val | output | CNT_W | Last captured counter value |
| chan_evt | output | 1 | One-cycle capture/match event |

## Verification
The checker watches every cycle for the following:

- The pin is never driven while E = 00.
- The disconnected preset level follows bit A.
- `cap_val` changes only in capture mode and always together with an event.
- Events occur only when a channel mode is connected.
- Clear and set matches leave the documented level.
- The active compare value changes only on a direct write or an overflow.
- Reset leaves the configuration cleared.

Edge qualification per code, the exact capture latency, toggle sequences, deferral of buffered writes across a match, and the absence of a capture when capture is enabled on a stable pin depend on chosen stimulus orderings. Only the directed scenarios show these.

// File: rtl/capcmp_pkg.sv
// Shared types for the capture/compare channel.
// Assumes the 4-bit configuration layout {B, A, E[1:0]}.
package capcmp_pkg;

    typedef struct packed {
        logic       mode_b;
        logic       mode_a;
        logic [1:0] edge_lvl;
    } cfg_t;

    typedef enum logic [1:0] {
        CH_OFF          = 2'b00,
        CH_CAPTURE      = 2'b01,
        CH_CMP_DIRECT   = 2'b10,
        CH_CMP_BUFFERED = 2'b11
    } ch_func_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } cmp_act_e;

endpackage

// File: rtl/capcmp_decode.sv
// Configuration decoder: turns the {B, A, E} field into a channel function,
// capture edge enables, compare action, pin drive enable and preset level.
// Purely combinational; assumes the field is registered by the caller.
module capcmp_decode
    import capcmp_pkg::*;
(
    input  cfg_t     cfg,
    output ch_func_e func,
    output logic     rise_en,
    output logic     fall_en,
    output cmp_act_e act,
    output logic     drive_en,
    output logic     preset_lvl
);

    // Function, edge and action selection from the configuration field.
    always_comb begin
        if (cfg.edge_lvl == 2'b00)
            func = CH_OFF;
        else if (cfg.mode_b)
            func = CH_CMP_BUFFERED;
        else if (cfg.mode_a)
            func = CH_CMP_DIRECT;
        else
            func = CH_CAPTURE;

        rise_en    = (func == CH_CAPTURE) && cfg.edge_lvl[0];
        fall_en    = (func == CH_CAPTURE) && cfg.edge_lvl[1];
        act        = cmp_act_e'(cfg.edge_lvl);
        drive_en   = (func == CH_CMP_DIRECT) || (func == CH_CMP_BUFFERED);
        preset_lvl = ~cfg.mode_a;
    end

endmodule

// File: rtl/capcmp_edge.sv
// Pin synchronizer and edge detector. SYNC_STAGES flops bring the raw pin
// into the clock domain; one more flop holds the previous synchronized value.
// Runs regardless of channel mode so a stable pin never looks like an edge.
// Assumes SYNC_STAGES >= 2.
module capcmp_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the pin through the synchronizer and keep the last settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_in};
            prev_q <= sync_q[LAST];
        end
    end

    // Edge flags from the settled value and its predecessor.
    always_comb begin
        rise = sync_q[LAST] & ~prev_q;
        fall = ~sync_q[LAST] & prev_q;
    end

endmodule

// File: rtl/capcmp_cmpreg.sv
// Compare value store with optional double buffering. An unbuffered write
// goes straight to the active register. A buffered write lands in a pending
// register that moves to the active one on the next overflow strobe.
// Also produces the counter equality match.
module capcmp_cmpreg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             buffered,
    input  logic             ovf,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] active_q,
    output logic             match
);

    logic [CNT_W-1:0] pend_q;
    logic             pend_vld_q;

    // Active register: direct write, or pending transfer at overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (wr_en && !buffered)
            active_q <= wr_data;
        else if (ovf && pend_vld_q)
            active_q <= pend_q;
    end

    // Pending register: captures buffered writes, empties at overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (wr_en && buffered) begin
            pend_q     <= wr_data;
            pend_vld_q <= 1'b1;
        end else if (ovf) begin
            pend_vld_q <= 1'b0;
        end
    end

    // Equality between the counter and the active compare value.
    always_comb match = (cnt_val == active_q);

endmodule

// File: rtl/capcmp_channel.sv
// One capture/compare channel of a free-running timer.
// Holds the configuration field and the channel output level. It combines
// pin edges and compare matches into capture, output actions and an event
// pulse. Assumes the configuration is written only while the counter is
// stopped, and that the counter moves on after a matching value.
module capcmp_channel
    import capcmp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_data,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             pin_in,
    output logic             pin_oe,
    output logic             pin_out,
    output logic [CNT_W-1:0] cap_val,
    output logic             chan_evt
);

    cfg_t             cfg_q;
    ch_func_e         func;
    cmp_act_e         act;
    logic             rise_en, fall_en, drive_en, preset_lvl;
    logic             rise, fall, match;
    logic             cap_hit, cmp_hit, lvl_q;
    logic [CNT_W-1:0] active_cmp;

    // Configuration register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_t'(cfg_data);
    end

    capcmp_decode u_decode (
        .cfg        (cfg_q),
        .func       (func),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .act        (act),
        .drive_en   (drive_en),
        .preset_lvl (preset_lvl)
    );

    capcmp_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    capcmp_cmpreg #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmp_we),
        .wr_data  (cmp_data),
        .buffered (cfg_q.mode_b),
        .ovf      (cnt_ovf),
        .cnt_val  (cnt_val),
        .active_q (active_cmp),
        .match    (match)
    );

    // Qualified capture and compare hits for this cycle.
    always_comb begin
        cap_hit = (rise & rise_en) | (fall & fall_en);
        cmp_hit = match & drive_en;
    end

    // Channel level: preset while disconnected, compare action on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= 1'b1;
        else if (func == CH_OFF)
            lvl_q <= preset_lvl;
        else if (cmp_hit) begin
            case (act)
                ACT_TOGGLE: lvl_q <= ~lvl_q;
                ACT_CLEAR:  lvl_q <= 1'b0;
                ACT_SET:    lvl_q <= 1'b1;
                default:    lvl_q <= lvl_q;
            endcase
        end
    end

    // Capture register and event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val  <= '0;
            chan_evt <= 1'b0;
        end else begin
            if (cap_hit)
                cap_val <= cnt_val;
            chan_evt <= cap_hit | cmp_hit;
        end
    end

    // Pin outputs.
    always_comb begin
        pin_oe  = drive_en;
        pin_out = lvl_q;
    end

endmodule

// File: rtl/capcmp_channel_chk.sv
// Property checker for capcmp_channel, attached by bind below.
// Observes the configuration register and the active compare value
// alongside the ports.
module capcmp_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cfg_bits,
    input logic             cnt_ovf,
    input logic             cmp_we,
    input logic [CNT_W-1:0] active_cmp,
    input logic             pin_oe,
    input logic             pin_out,
    input logic [CNT_W-1:0] cap_val,
    input logic             chan_evt
);

    AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[1:0] == 2'b00) |-> !pin_oe); // R1

    AST_PRESET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[1:0] == 2'b00) |=> (pin_out == !$past(cfg_bits[2]))); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cfg_bits == 4'b0000 && !chan_evt)); // R3

    AST_CAPTURE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> ($past(cfg_bits[3:2]) == 2'b00 &&
                               $past(cfg_bits[1:0]) != 2'b00 && chan_evt)); // R4

    AST_EVT_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
        chan_evt |-> ($past(cfg_bits[1:0]) != 2'b00)); // R1

    AST_CLEAR_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_evt && $past(cfg_bits[3:2] != 2'b00 && cfg_bits[1:0] == 2'b10))
        |-> !pin_out); // R5

    AST_SET_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_evt && $past(cfg_bits[3:2] != 2'b00 && cfg_bits[1:0] == 2'b11))
        |-> pin_out); // R5

    AST_ACTIVE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_cmp) |->
            ($past(cnt_ovf) || ($past(cmp_we) && !$past(cfg_bits[3])))); // R6

endmodule

bind capcmp_channel capcmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bits   (cfg_q),
    .cnt_ovf    (cnt_ovf),
    .cmp_we     (cmp_we),
    .active_cmp (active_cmp),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .cap_val    (cap_val),
    .chan_evt   (chan_evt)
);

// File: tb/capcmp_channel_tb.sv
`timescale 1ns/1ps
// Directed bench for capcmp_channel. Inputs change on falling edges and
// outputs are sampled on falling edges. Before every mode change the bench
// holds the counter value still, standing in for a stopped counter.
module capcmp_channel_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             cnt_ovf = 1'b0;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_data = '0;
    logic             cmp_we = 1'b0;
    logic [CNT_W-1:0] cmp_data = '0;
    logic             pin_in = 1'b0;
    logic             pin_oe, pin_out, chan_evt;
    logic [CNT_W-1:0] cap_val;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    capcmp_channel #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .cmp_we(cmp_we),
        .cmp_data(cmp_data), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .cap_val(cap_val), .chan_evt(chan_evt)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] d);
        cfg_we = 1'b1; cfg_data = d;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic cmp_write(input logic [CNT_W-1:0] d);
        cmp_we = 1'b1; cmp_data = d;
        step(1);
        cmp_we = 1'b0;
    endtask

    // Counter sits on v for one cycle, then moves to a neutral value.
    task automatic hit(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] after);
        cnt_val = v;
        step(1);
        cnt_val = after;
    endtask

    task automatic t_reset;
        chk("R3 oe", pin_oe, 0);
        chk("R3 level", pin_out, 1);
        chk("R3 cap", cap_val, 0);
        chk("R3 evt", chan_evt, 0);
    endtask

    task automatic t_preset;
        cfg_write(4'b0100); step(1);
        chk("R2 preset low", pin_out, 0);
        chk("R1 no drive", pin_oe, 0);
        cfg_write(4'b0000); step(1);
        chk("R2 preset high", pin_out, 1);
        chk("R1 no drive", pin_oe, 0);
    endtask

    task automatic t_unbuffered;
        cnt_val = 16'd50;
        cmp_write(16'd100);
        cfg_write(4'b0100); step(1);
        cfg_write(4'b0111);
        chk("R8 oe compare", pin_oe, 1);
        chk("R2 carried level", pin_out, 0);
        hit(16'd100, 16'd101);
        chk("R5 set evt", chan_evt, 1);
        chk("R5 set level", pin_out, 1);
        step(1);
        chk("R5 evt pulse ends", chan_evt, 0);
        cfg_write(4'b0101);
        hit(16'd100, 16'd101);
        chk("R5 toggle 1", pin_out, 0);
        step(1);
        hit(16'd100, 16'd101);
        chk("R5 toggle 2", pin_out, 1);
        cfg_write(4'b0110);
        hit(16'd100, 16'd101);
        chk("R5 clear", pin_out, 0);
        cmp_write(16'd300);
        cfg_write(4'b0111);
        hit(16'd100, 16'd301);
        chk("R7 old value gone", chan_evt, 0);
        hit(16'd300, 16'd301);
        chk("R7 new value active", chan_evt, 1);
        chk("R7 set level", pin_out, 1);
        step(1);
    endtask

    task automatic t_buffered;
        cfg_write(4'b1001);
        chk("R8 oe buffered", pin_oe, 1);
        cmp_write(16'd200);
        hit(16'd200, 16'd201);
        chk("R6 pending not active", chan_evt, 0);
        hit(16'd300, 16'd301);
        chk("R6 old value still matches", chan_evt, 1);
        chk("R6 toggle", pin_out, 0);
        cnt_val = 16'd0; cnt_ovf = 1'b1;
        step(1);
        cnt_ovf = 1'b0;
        hit(16'd200, 16'd201);
        chk("R6 transferred at overflow", chan_evt, 1);
        chk("R6 toggle back", pin_out, 1);
        step(1);
    endtask

    task automatic t_capture;
        cfg_write(4'b0000);
        pin_in = 1'b0; step(4);
        cfg_write(4'b0001);
        chk("R8 oe capture", pin_oe, 0);
        cnt_val = 16'h1234; pin_in = 1'b1;
        step(2);
        chk("R4 latency", chan_evt, 0);
        step(1);
        chk("R4 rising evt", chan_evt, 1);
        chk("R4 rising cap", cap_val, 16'h1234);
        step(1);
        chk("R4 evt one cycle", chan_evt, 0);
        cnt_val = 16'h2222; pin_in = 1'b0;
        step(4);
        chk("R4 falling ignored cap", cap_val, 16'h1234);
        cfg_write(4'b0010);
        cnt_val = 16'h3333; pin_in = 1'b1;
        step(3);
        chk("R4 rising ignored", chan_evt, 0);
        pin_in = 1'b0;
        step(3);
        chk("R4 falling evt", chan_evt, 1);
        chk("R4 falling cap", cap_val, 16'h3333);
        cfg_write(4'b0011);
        cnt_val = 16'h4444; pin_in = 1'b1;
        step(3);
        chk("R4 both rise cap", cap_val, 16'h4444);
        cnt_val = 16'h5555; pin_in = 1'b0;
        step(3);
        chk("R4 both fall evt", chan_evt, 1);
        chk("R4 both fall cap", cap_val, 16'h5555);
        cnt_val = 16'd200;
        step(2);
        chk("R10 no match in capture", chan_evt, 0);
        chk("R10 cap kept", cap_val, 16'h5555);
    endtask

    task automatic t_enable_stable;
        cfg_write(4'b0000);
        cnt_val = 16'h0777; pin_in = 1'b1;
        step(5);
        cfg_write(4'b0011);
        for (int i = 0; i < 4; i++) begin
            chk("R9 no event at enable", chan_evt, 0);
            step(1);
        end
        chk("R9 cap unchanged", cap_val, 16'h5555);
    endtask

    task automatic t_cmp_ignores_pin;
        cfg_write(4'b0000);
        cnt_val = 16'd7;
        cfg_write(4'b0101);
        pin_in = 1'b0;
        step(4);
        chk("R10 pin edge no evt", chan_evt, 0);
        chk("R10 pin edge no cap", cap_val, 16'h5555);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_preset();
        t_unbuffered();
        t_buffered();
        t_capture();
        t_enable_stable();
        t_cmp_ignores_pin();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule